// File: doc/BRIEF.md
# Sa National Bit Buffer with Change Interrupts

This block sits beside a 2.048 Mb/s framer. It collects the five spare national bits (Sa4 to Sa8) that arrive in the non-frame-alignment words of a CRC-4 multiframe. Each Sa position gets a byte-wide receive buffer. Every odd frame (1, 3, ..., 15) contributes one bit to each buffer. At each receive multiframe boundary the assembled bytes are latched into the buffers that software reads.

The block also compares the new data with what came before. It keeps sticky flags for three events: an Sa byte that differs from the previous multiframe, a four-bit Sa nibble that differs from the nibble before it, and the multiframe boundary itself. Any Sa position currently claimed by the data link is left out of the change detection.

On the transmit side, five shadow bytes are written by software and moved into active use at the next transmit multiframe start. They are then served bit by bit on each transmit request. A data-link override replaces the buffered bit for any selected position.

Top module: `sa_nbb`

## Requirements
- R1: Register addresses 0 to 4 read the latched receive bytes for Sa4, Sa5, Sa6, Sa7 and Sa8. The bit received with frame index i (0 = frame 1 ... 7 = frame 15) lands in bit 7-i. The bytes change only on a cycle with `rx_mf_start` high, and then take the bits gathered since the previous boundary.
- R2: A read with `reg_rd` high returns its data on `reg_rdata` one clock later. Unused addresses and unused bits read as 0.
- R3: Register 10, bit k (k = 0 for Sa4 ... 4 for Sa8), is set at a receive boundary when the newly latched byte differs from the previously latched byte. No such flag is set at the first boundary after reset.
- R4: An Sa position whose `dl_sel` bit is high at the moment of detection never sets its byte-change flag or its nibble-change flag.
- R5: Register 11, bits 3:0 (Sa5 to Sa8), is set when a completed nibble differs from the previously completed nibble of the same Sa position. A nibble is frames 1-7 (completed at index 3) or frames 9-15 (completed at index 7), with the older frame in the upper bit. Nibbles are compared across multiframe boundaries. The first nibble after reset is never flagged.
- R6: Register 12, bit 0, is set on every cycle with `rx_mf_start` high.
- R7: All flags in registers 10 to 12 stay set until a write puts a 1 in their bit. A flag set and a clear in the same cycle leaves the flag set.
- R8: `irq` is high one clock after any flag is set whose enable is 1. Register 13, bits 4:0, enables the byte-change flags. Register 14, bits 3:0, enables the nibble-change flags, and bit 4 enables the boundary flag.
- R9: Registers 5 to 9 hold the transmit shadow bytes for Sa4 to Sa8 and read back as written. A shadow byte is used for transmission only after the next `tx_mf_start`.
- R10: One clock after `tx_nfas_req`, `tx_sa` bit k equals bit 7-`tx_frm_idx` of the active byte for position k. If `dl_sel[k]` is high, it equals `dl_tx[k]` instead. `tx_sa` holds between requests.
- R11: After reset all buffers, flags, enables, `irq`, `tx_sa` and `reg_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_mf_start | input | 1 | Receive multiframe boundary pulse |
| rx_nfas_vld | input | 1 | Receive odd-frame Sa bits valid |
| rx_frm_idx | input | 3 | Odd-frame index 0..7 of the received bits |
| rx_sa | input | 5 | Received Sa4..Sa8 bits (bit 0 = Sa4) |
| tx_mf_start | input | 1 | Transmit multiframe boundary pulse |
| tx_nfas_req | input | 1 | Request for the next transmit Sa bits |
| tx_frm_idx | input | 3 | Odd-frame index of the request |
| tx_sa | output | 5 | Transmit Sa4..Sa8 bits |
| dl_sel | input | 5 | Sa positions taken by the data link |
| dl_tx | input | 5 | Data link bits for the taken positions |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a new change event that lands in the same cycle as a software clear of the same flag. The stimulus lines up a register write to the byte-change flags with the `rx_mf_start` pulse of a multiframe whose Sa4 and Sa6 bytes differ from the previous one.

A related corner is nibble comparison across a boundary while a position is claimed by the data link. One multiframe is sent with Sa6 selected, and then the selection is released. The excluded nibble still becomes the reference for the next comparison.

// File: rtl/sa_nbb_pkg.sv
package sa_nbb_pkg;
  localparam int unsigned SA_CNT_DEF  = 5;
  localparam int unsigned FRM_CNT_DEF = 8;
  localparam int unsigned REG_AW_DEF  = 4;
  localparam int unsigned REG_DW_DEF  = 8;
  // control slots placed after the receive and transmit byte banks
  localparam int unsigned OFS_BIT_FLG = 0;
  localparam int unsigned OFS_NIB_FLG = 1;
  localparam int unsigned OFS_STAT    = 2;
  localparam int unsigned OFS_BIT_MSK = 3;
  localparam int unsigned OFS_NIB_MSK = 4;
endpackage

// File: rtl/sa_rx_collect.sv
module sa_rx_collect #(
  parameter int unsigned NSA  = sa_nbb_pkg::SA_CNT_DEF,
  parameter int unsigned NFRM = sa_nbb_pkg::FRM_CNT_DEF,
  localparam int unsigned IDXW = $clog2(NFRM),
  localparam int unsigned HALF = NFRM / 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mf_start,
  input  logic                       nfas_vld,
  input  logic [IDXW-1:0]            frm_idx,
  input  logic [NSA-1:0]             sa_bits,
  input  logic [NSA-1:0]             dl_sel,
  output logic [NSA-1:0][NFRM-1:0]   rx_buf,
  output logic [NSA-1:0]             bit_evt,
  output logic [NSA-2:0]             nib_evt
);
  logic [NSA-1:0][NFRM-1:0] asm_q, asm_nx;
  logic [IDXW-1:0]          pos;
  logic                     buf_ok;
  logic                     nib_done;

  assign pos      = IDXW'(NFRM-1) - frm_idx;
  assign nib_done = nfas_vld && (&frm_idx[IDXW-2:0]);

  always_comb begin
    asm_nx = asm_q;
    if (nfas_vld) begin
      for (int k = 0; k < NSA; k++) asm_nx[k][pos] = sa_bits[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      asm_q  <= '0;
      rx_buf <= '0;
      buf_ok <= 1'b0;
    end else begin
      asm_q <= asm_nx;
      if (mf_start) begin
        rx_buf <= asm_q;
        buf_ok <= 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NSA; g++) begin : g_byte
      assign bit_evt[g] = mf_start && buf_ok && !dl_sel[g] && (asm_q[g] != rx_buf[g]);
    end
    for (g = 1; g < NSA; g++) begin : g_nib
      logic [HALF-1:0] last_q;
      logic [HALF-1:0] nib_val;
      logic            ok_q;
      assign nib_val = frm_idx[IDXW-1] ? asm_nx[g][HALF-1:0] : asm_nx[g][NFRM-1:HALF];
      always_ff @(posedge clk) begin
        if (rst) begin
          last_q <= '0;
          ok_q   <= 1'b0;
        end else if (nib_done) begin
          last_q <= nib_val;
          ok_q   <= 1'b1;
        end
      end
      assign nib_evt[g-1] = nib_done && ok_q && !dl_sel[g] && (nib_val != last_q);
    end
  endgenerate
endmodule

// File: rtl/sa_tx_source.sv
module sa_tx_source #(
  parameter int unsigned NSA  = sa_nbb_pkg::SA_CNT_DEF,
  parameter int unsigned NFRM = sa_nbb_pkg::FRM_CNT_DEF,
  localparam int unsigned IDXW = $clog2(NFRM)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mf_start,
  input  logic                     req,
  input  logic [IDXW-1:0]          frm_idx,
  input  logic [NSA-1:0][NFRM-1:0] shadow,
  input  logic [NSA-1:0]           dl_sel,
  input  logic [NSA-1:0]           dl_tx,
  output logic [NSA-1:0][NFRM-1:0] tx_act,
  output logic [NSA-1:0]           tx_sa
);
  logic [IDXW-1:0] pos;
  assign pos = IDXW'(NFRM-1) - frm_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_act <= '0;
      tx_sa  <= '0;
    end else begin
      if (mf_start) tx_act <= shadow;
      if (req) begin
        for (int k = 0; k < NSA; k++)
          tx_sa[k] <= dl_sel[k] ? dl_tx[k] : tx_act[k][pos];
      end
    end
  end
endmodule

// File: rtl/sa_regs.sv
module sa_regs #(
  parameter int unsigned NSA  = sa_nbb_pkg::SA_CNT_DEF,
  parameter int unsigned NFRM = sa_nbb_pkg::FRM_CNT_DEF,
  parameter int unsigned AW   = sa_nbb_pkg::REG_AW_DEF,
  parameter int unsigned DW   = sa_nbb_pkg::REG_DW_DEF,
  localparam int unsigned NNIB     = NSA - 1,
  localparam int unsigned TX_BASE  = NSA,
  localparam int unsigned CTL_BASE = 2 * NSA
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            addr,
  input  logic                     wr,
  input  logic [DW-1:0]            wdata,
  input  logic                     rd,
  output logic [DW-1:0]            rdata,
  input  logic [NSA-1:0][NFRM-1:0] rx_buf,
  input  logic [NSA-1:0]           bit_evt,
  input  logic [NNIB-1:0]          nib_evt,
  input  logic                     mf_evt,
  output logic [NSA-1:0][NFRM-1:0] tx_shadow,
  output logic [NSA-1:0]           bit_flg,
  output logic [NNIB-1:0]          nib_flg,
  output logic                     mf_flg,
  output logic                     irq
);
  import sa_nbb_pkg::*;

  logic [NSA-1:0]  bit_msk;
  logic [NNIB-1:0] nib_msk;
  logic            mf_msk;
  logic [DW-1:0]   rd_nx;
  logic hit_bf, hit_nf, hit_st, hit_bm, hit_nm;

  assign hit_bf = (addr == AW'(CTL_BASE + OFS_BIT_FLG));
  assign hit_nf = (addr == AW'(CTL_BASE + OFS_NIB_FLG));
  assign hit_st = (addr == AW'(CTL_BASE + OFS_STAT));
  assign hit_bm = (addr == AW'(CTL_BASE + OFS_BIT_MSK));
  assign hit_nm = (addr == AW'(CTL_BASE + OFS_NIB_MSK));

  always_comb begin
    rd_nx = '0;
    for (int k = 0; k < NSA; k++) begin
      if (addr == AW'(k))           rd_nx = DW'(rx_buf[k]);
      if (addr == AW'(TX_BASE + k)) rd_nx = DW'(tx_shadow[k]);
    end
    if (hit_bf) rd_nx = DW'(bit_flg);
    if (hit_nf) rd_nx = DW'(nib_flg);
    if (hit_st) rd_nx = DW'(mf_flg);
    if (hit_bm) rd_nx = DW'(bit_msk);
    if (hit_nm) rd_nx = DW'({mf_msk, nib_msk});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_flg   <= '0;
      nib_flg   <= '0;
      mf_flg    <= 1'b0;
      bit_msk   <= '0;
      nib_msk   <= '0;
      mf_msk    <= 1'b0;
      tx_shadow <= '0;
      rdata     <= '0;
      irq       <= 1'b0;
    end else begin
      bit_flg <= (bit_flg & ~((wr && hit_bf) ? wdata[NSA-1:0]  : '0)) | bit_evt;
      nib_flg <= (nib_flg & ~((wr && hit_nf) ? wdata[NNIB-1:0] : '0)) | nib_evt;
      mf_flg  <= (mf_flg & ~(wr && hit_st && wdata[0])) | mf_evt;
      if (wr && hit_bm) bit_msk <= wdata[NSA-1:0];
      if (wr && hit_nm) begin
        nib_msk <= wdata[NNIB-1:0];
        mf_msk  <= wdata[NNIB];
      end
      for (int k = 0; k < NSA; k++)
        if (wr && addr == AW'(TX_BASE + k)) tx_shadow[k] <= wdata[NFRM-1:0];
      if (rd) rdata <= rd_nx;
      irq <= (|(bit_flg & bit_msk)) | (|(nib_flg & nib_msk)) | (mf_flg & mf_msk);
    end
  end
endmodule

// File: rtl/sa_nbb.sv
module sa_nbb #(
  parameter int unsigned NSA  = sa_nbb_pkg::SA_CNT_DEF,
  parameter int unsigned NFRM = sa_nbb_pkg::FRM_CNT_DEF,
  parameter int unsigned AW   = sa_nbb_pkg::REG_AW_DEF,
  parameter int unsigned DW   = sa_nbb_pkg::REG_DW_DEF,
  localparam int unsigned IDXW = $clog2(NFRM)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_mf_start,
  input  logic            rx_nfas_vld,
  input  logic [IDXW-1:0] rx_frm_idx,
  input  logic [NSA-1:0]  rx_sa,
  input  logic            tx_mf_start,
  input  logic            tx_nfas_req,
  input  logic [IDXW-1:0] tx_frm_idx,
  output logic [NSA-1:0]  tx_sa,
  input  logic [NSA-1:0]  dl_sel,
  input  logic [NSA-1:0]  dl_tx,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            reg_rd,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq
);
  logic [NSA-1:0][NFRM-1:0] rx_buf;
  logic [NSA-1:0][NFRM-1:0] tx_shadow;
  logic [NSA-1:0][NFRM-1:0] tx_act;
  logic [NSA-1:0]           bit_evt;
  logic [NSA-2:0]           nib_evt;
  logic [NSA-1:0]           bit_flg;
  logic [NSA-2:0]           nib_flg;
  logic                     mf_flg;

  sa_rx_collect #(.NSA(NSA), .NFRM(NFRM)) u_rx (
    .clk(clk), .rst(rst), .mf_start(rx_mf_start), .nfas_vld(rx_nfas_vld),
    .frm_idx(rx_frm_idx), .sa_bits(rx_sa), .dl_sel(dl_sel),
    .rx_buf(rx_buf), .bit_evt(bit_evt), .nib_evt(nib_evt)
  );

  sa_tx_source #(.NSA(NSA), .NFRM(NFRM)) u_tx (
    .clk(clk), .rst(rst), .mf_start(tx_mf_start), .req(tx_nfas_req),
    .frm_idx(tx_frm_idx), .shadow(tx_shadow), .dl_sel(dl_sel), .dl_tx(dl_tx),
    .tx_act(tx_act), .tx_sa(tx_sa)
  );

  sa_regs #(.NSA(NSA), .NFRM(NFRM), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rd(reg_rd), .rdata(reg_rdata), .rx_buf(rx_buf), .bit_evt(bit_evt),
    .nib_evt(nib_evt), .mf_evt(rx_mf_start), .tx_shadow(tx_shadow),
    .bit_flg(bit_flg), .nib_flg(nib_flg), .mf_flg(mf_flg), .irq(irq)
  );
endmodule

// File: rtl/sa_nbb_chk.sv
module sa_nbb_chk #(
  parameter int unsigned NSA  = 5,
  parameter int unsigned NFRM = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     rx_mf_start,
  input logic                     tx_mf_start,
  input logic                     tx_nfas_req,
  input logic [NSA-1:0]           dl_sel,
  input logic [NSA-1:0]           dl_tx,
  input logic [NSA-1:0]           tx_sa,
  input logic                     irq,
  input logic [NSA-1:0][NFRM-1:0] rx_buf,
  input logic [NSA-1:0][NFRM-1:0] tx_act,
  input logic [NSA-1:0]           bit_flg,
  input logic [NSA-2:0]           nib_flg,
  input logic                     mf_flg
);
  AST_RXBUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_mf_start |=> $stable(rx_buf)); // R1
  AST_TXACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tx_mf_start |=> $stable(tx_act)); // R9
  AST_MF_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    rx_mf_start |=> mf_flg); // R6
  AST_DL_NO_BIT_FLAG: assert property (@(posedge clk) disable iff (rst)
    ((bit_flg & ~$past(bit_flg)) & $past(dl_sel)) == '0); // R4
  AST_TXSA_DL_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    tx_nfas_req |=> ((tx_sa ^ $past(dl_tx)) & $past(dl_sel)) == '0); // R10
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bit_flg == '0 && nib_flg == '0 && !mf_flg) |=> !irq); // R8
endmodule

bind sa_nbb sa_nbb_chk #(.NSA(NSA), .NFRM(NFRM)) u_chk (
  .clk(clk), .rst(rst), .rx_mf_start(rx_mf_start), .tx_mf_start(tx_mf_start),
  .tx_nfas_req(tx_nfas_req), .dl_sel(dl_sel), .dl_tx(dl_tx), .tx_sa(tx_sa),
  .irq(irq), .rx_buf(rx_buf), .tx_act(tx_act), .bit_flg(bit_flg),
  .nib_flg(nib_flg), .mf_flg(mf_flg)
);

// File: tb/sim_sa_nbb.sv
module sim_sa_nbb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_mf_start = 0, rx_nfas_vld = 0, tx_mf_start = 0, tx_nfas_req = 0;
  logic [2:0] rx_frm_idx = 0, tx_frm_idx = 0;
  logic [4:0] rx_sa = 0, dl_sel = 0, dl_tx = 0, tx_sa;
  logic [3:0] reg_addr = 0;
  logic       reg_wr = 0, reg_rd = 0, irq;
  logic [7:0] reg_wdata = 0, reg_rdata;

  always #10 clk = ~clk;

  sa_nbb u0 (.*);

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_asm[5], m_buf[5], m_sh[5], m_act[5], m_last[5];
  bit m_nok[5];
  bit m_bok, m_irq;
  int m_bf, m_nf, m_mf, m_bm, m_nm, m_mm, m_rd, m_tx;

  function automatic int model_read(input int a);
    if (a < 5) return m_buf[a];
    if (a < 10) return m_sh[a-5];
    case (a)
      10: return m_bf;
      11: return m_nf;
      12: return m_mf;
      13: return m_bm;
      14: return m_nm | (m_mm << 4);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int na[5];
    int bev, nev, pos, nib;
    if (rst) begin
      for (int k = 0; k < 5; k++) begin
        m_asm[k] = 0; m_buf[k] = 0; m_sh[k] = 0; m_act[k] = 0; m_last[k] = 0; m_nok[k] = 0;
      end
      m_bok = 0; m_irq = 0; m_bf = 0; m_nf = 0; m_mf = 0;
      m_bm = 0; m_nm = 0; m_mm = 0; m_rd = 0; m_tx = 0;
    end else begin
      if (reg_rd) m_rd = model_read(int'(reg_addr));
      m_irq = ((m_bf & m_bm) | (m_nf & m_nm) | (m_mf & m_mm)) != 0;
      if (tx_nfas_req) begin
        m_tx = 0;
        for (int k = 0; k < 5; k++)
          if (dl_sel[k]) m_tx |= int'(dl_tx[k]) << k;
          else m_tx |= ((m_act[k] >> (7 - int'(tx_frm_idx))) & 1) << k;
      end
      bev = 0;
      if (rx_mf_start && m_bok)
        for (int k = 0; k < 5; k++)
          if (!dl_sel[k] && m_asm[k] != m_buf[k]) bev |= 1 << k;
      pos = 7 - int'(rx_frm_idx);
      for (int k = 0; k < 5; k++) begin
        na[k] = m_asm[k];
        if (rx_nfas_vld) na[k] = (na[k] & ~(1 << pos)) | (int'(rx_sa[k]) << pos);
      end
      nev = 0;
      if (rx_nfas_vld && (int'(rx_frm_idx) % 4) == 3)
        for (int k = 1; k < 5; k++) begin
          nib = (rx_frm_idx == 3) ? ((na[k] >> 4) & 15) : (na[k] & 15);
          if (m_nok[k] && !dl_sel[k] && nib != m_last[k]) nev |= 1 << (k - 1);
          m_last[k] = nib;
          m_nok[k] = 1;
        end
      if (rx_mf_start) begin
        for (int k = 0; k < 5; k++) m_buf[k] = m_asm[k];
        m_bok = 1;
      end
      for (int k = 0; k < 5; k++) m_asm[k] = na[k];
      if (tx_mf_start) for (int k = 0; k < 5; k++) m_act[k] = m_sh[k];
      if (reg_wr) begin
        case (int'(reg_addr))
          10: m_bf &= ~int'(reg_wdata);
          11: m_nf &= ~int'(reg_wdata);
          12: m_mf &= ~(int'(reg_wdata) & 1);
          13: m_bm = int'(reg_wdata) & 31;
          14: begin m_nm = int'(reg_wdata) & 15; m_mm = (int'(reg_wdata) >> 4) & 1; end
          default: if (reg_addr >= 5 && reg_addr <= 9) m_sh[int'(reg_addr) - 5] = int'(reg_wdata);
        endcase
      end
      m_bf |= bev;
      m_nf |= nev;
      if (rx_mf_start) m_mf = 1;
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(reg_rdata) == (m_rd & 255), "R2 reg_rdata vs model", int'(reg_rdata), m_rd & 255);
      chk(irq == m_irq, "R8 irq vs model", int'(irq), int'(m_irq));
      chk(int'(tx_sa) == m_tx, "R10 tx_sa vs model", int'(tx_sa), m_tx);
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk); reg_wr = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); reg_rd = 1; reg_addr = 4'(a);
    @(negedge clk); reg_rd = 0;
    chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
  endtask

  task automatic send_frames(input logic [4:0][7:0] p);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rx_nfas_vld = 1; rx_frm_idx = 3'(i);
      for (int k = 0; k < 5; k++) rx_sa[k] = p[k][7-i];
      @(negedge clk); rx_nfas_vld = 0;
    end
  endtask

  task automatic rx_boundary();
    @(negedge clk); rx_mf_start = 1;
    @(negedge clk); rx_mf_start = 0;
  endtask

  task automatic tx_req(input int idx);
    @(negedge clk); tx_nfas_req = 1; tx_frm_idx = 3'(idx);
    @(negedge clk); tx_nfas_req = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(irq == 0, "R11 irq after reset", int'(irq), 0);
    chk(tx_sa == 0, "R11 tx_sa after reset", int'(tx_sa), 0);
    rd_chk(10, 0, "R11 byte flags after reset");
    rd_chk(0, 0, "R11 rx byte after reset");

    wr_reg(13, 8'h1F);
    wr_reg(14, 8'h1F);
    rd_chk(14, 8'h1F, "R8 enable register readback");

    // first multiframe: Sa4..Sa8 = A5 3C FF 00 81
    send_frames({8'h81, 8'h00, 8'hFF, 8'h3C, 8'hA5});
    rx_boundary();
    rd_chk(0, 8'hA5, "R1 Sa4 byte frame 1 in bit 7");
    rd_chk(4, 8'h81, "R1 Sa8 byte");
    rd_chk(10, 0, "R3 no byte flag at first boundary");
    rd_chk(11, 8'h09, "R5 nibble flags Sa5 and Sa8");
    rd_chk(12, 1, "R6 boundary flag");
    rd_chk(15, 0, "R2 unused address reads 0");
    chk(irq == 1, "R8 irq with enabled flags", int'(irq), 1);

    wr_reg(11, 8'h09);
    wr_reg(12, 1);
    rd_chk(11, 0, "R7 nibble flags cleared by write of 1");
    rd_chk(10, 0, "R7 byte flags unchanged by other clear");

    // second multiframe with Sa6 taken by the data link
    dl_sel = 5'b00100;
    send_frames({8'h81, 8'h00, 8'hF7, 8'h3C, 8'hA4});
    rx_boundary();
    dl_sel = 5'b00000;
    rd_chk(10, 8'h01, "R3 R4 Sa4 change flagged, Sa6 excluded");
    rd_chk(11, 8'h09, "R4 R5 nibble flags without Sa6");
    rd_chk(2, 8'hF7, "R1 excluded position still buffered");

    wr_reg(10, 8'h1F);
    wr_reg(11, 8'h0F);
    wr_reg(12, 1);

    // third multiframe: clear written in the boundary cycle
    send_frames({8'h81, 8'h00, 8'hFF, 8'h3C, 8'hA5});
    @(negedge clk);
    rx_mf_start = 1; reg_wr = 1; reg_addr = 4'd10; reg_wdata = 8'h1F;
    @(negedge clk);
    rx_mf_start = 0; reg_wr = 0;
    rd_chk(10, 8'h05, "R7 set wins over same-cycle clear");
    rd_chk(11, 8'h0B, "R5 nibble change across boundary and after link release");

    // disable interrupts and clear everything
    wr_reg(13, 0);
    wr_reg(14, 0);
    wr_reg(10, 8'h1F);
    wr_reg(11, 8'h0F);
    wr_reg(12, 1);
    @(negedge clk);
    chk(irq == 0, "R8 irq low with enables off", int'(irq), 0);
    rx_boundary();
    @(negedge clk);
    chk(irq == 0, "R8 masked boundary flag keeps irq low", int'(irq), 0);
    rd_chk(12, 1, "R6 flag set although masked");

    // transmit side
    wr_reg(5, 8'hC3);
    rd_chk(5, 8'hC3, "R9 shadow readback");
    tx_req(0);
    chk(tx_sa[0] == 0, "R9 shadow not active before tx boundary", int'(tx_sa[0]), 0);
    @(negedge clk); tx_mf_start = 1;
    @(negedge clk); tx_mf_start = 0;
    tx_req(0);
    chk(tx_sa[0] == 1, "R10 frame 1 from bit 7", int'(tx_sa[0]), 1);
    tx_req(2);
    chk(tx_sa[0] == 0, "R10 frame 5 from bit 5", int'(tx_sa[0]), 0);
    tx_req(7);
    chk(tx_sa[0] == 1, "R10 frame 15 from bit 0", int'(tx_sa[0]), 1);
    repeat (3) @(negedge clk);
    chk(tx_sa[0] == 1, "R10 tx_sa holds between requests", int'(tx_sa[0]), 1);
    dl_sel = 5'b00001; dl_tx = 5'b00000;
    tx_req(0);
    chk(tx_sa[0] == 0, "R10 data link override low", int'(tx_sa[0]), 0);
    dl_tx = 5'b00001;
    tx_req(2);
    chk(tx_sa[0] == 1, "R10 data link override high", int'(tx_sa[0]), 1);
    dl_sel = 0; dl_tx = 0;

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule